// File: doc/BRIEF.md
# Sized Integer ALU with Condition Codes

This block is the execute slice of a 32-bit integer core. One operation is presented with a source value, a destination register value, the current five-bit condition code and an operand size (byte, word or long). The block returns the new destination register value and the updated condition code. For byte and word sizes it writes only the low 8 or 16 bits and passes the upper bits of the destination through unchanged. Each operation has its own rule for which flags it sets and which it keeps.

Most operations finish in a single clocked step. The supported operations are add, subtract, compare, address add with sign extension, half swap, 16x16 unsigned multiply, and logical, arithmetic and rotating shifts. Unsigned divide is a restoring divider that produces one quotient bit per cycle and keeps the block busy while it runs. A divide that cannot produce a valid 16-bit quotient is rejected at once: it raises an error pulse and leaves the destination as it was.

Top module: `flag_alu`

## Requirements
- R1: For operation codes that honour the size (ADD=0, SUB=1, shifts 6..10), sizeSel=0 (byte) replaces only bits 7:0 of resultVal and sizeSel=1 (word) only bits 15:0. The other bits equal dstVal. sizeSel=2 or 3 (long) replaces all 32 bits.
- R2: ADD (opSel=0) yields dst+src at the selected size. ccrOut bits are X=4, N=3, Z=2, V=1, C=0. C is the carry out of the sized MSB and X equals C. V is set when both operands have the same sign and the result sign differs. N is the sized MSB. Z tests only the sized bits.
- R3: SUB (opSel=1) yields dst-src at the selected size. C is the borrow and X equals C. V is set when the operand signs differ and the result sign differs from dst. N and Z follow the sized result.
- R4: CMP (opSel=2) sets N, Z, V and C exactly as SUB would. It keeps X from ccrIn and returns dstVal unchanged.
- R5: ADDA (opSel=3) adds src to the full 32-bit dst. With sizeSel 0 or 1, src[15:0] is first sign-extended; with sizeSel 2 or 3, all of src is used. ccrOut equals ccrIn.
- R6: SWAP (opSel=4) returns dst with its 16-bit halves exchanged. N is bit 31 and Z tests all 32 bits. V and C are 0 and X is kept.
- R7: MULU (opSel=5) returns dst[15:0]*src[15:0] as 32 bits. N is bit 31 and Z tests all 32 bits. V and C are 0 and X is kept.
- R8: LSL=6, LSR=7 and ASR=8 shift the sized dst by src[5:0] positions. LSL and LSR fill with zeros; ASR fills with the sign bit. C and X take the last bit shifted out, and V is 0. With a count of 0 the value is unchanged, C is 0 and X is kept.
- R9: ROL=9 and ROR=10 rotate the sized dst by src[5:0] modulo the size. C is the last bit moved (result bit 0 for ROL, the sized MSB for ROR), or 0 when the count is 0. X is kept and V is 0.
- R10: DIVU (opSel=11) divides the 32-bit dst by src[15:0] and returns remainder in bits 31:16 and quotient in bits 15:0. N is quotient bit 15 and Z is set when the quotient is 0. V and C are 0 and X is kept. busy is high from the cycle after start until done, and done arrives 17 cycles after the start edge.
- R11: A DIVU with divisor 0, or with dst[31:16] >= divisor (the quotient would overflow), completes in one cycle. It pulses divErr with done and leaves resultVal equal to dstVal. C is 0 and X, N and Z are kept. V is 1 on overflow and 0 on divide by zero.
- R12: For every operation except an accepted divide, resultVal and ccrOut are valid with a one-cycle done pulse in the cycle after start is sampled. start is ignored while busy is high.
- R13: After reset resultVal, ccrOut, done, busy and divErr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the operation on the operand inputs |
| opSel | input | 4 | Operation code |
| sizeSel | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| srcVal | input | 32 | Source operand (also shift count and divisor) |
| dstVal | input | 32 | Destination register value |
| ccrIn | input | 5 | Current condition code {X,N,Z,V,C} |
| resultVal | output | 32 | New destination register value |
| ccrOut | output | 5 | New condition code {X,N,Z,V,C} |
| done | output | 1 | One-cycle pulse: results valid |
| busy | output | 1 | Divide in progress |
| divErr | output | 1 | Pulse with done when a divide is rejected |

## Verification
A wrong carry or sign index shows up in the flags of the same done cycle. The byte carries and the cases where the word result goes negative each expose such an error on their own. A merge mask that is too wide shows in the upper bits of resultVal straight away. A divider step counter or partial remainder that goes wrong only shows at the end of the run, as a done that comes early or late or as a wrong quotient or remainder 17 cycles after start. An operation that should have been ignored while busy would show as an extra done pulse or an overwritten result.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int CCR_W  = 5;
  localparam int CNT_W  = 6;

  localparam int X_BIT = 4;
  localparam int N_BIT = 3;
  localparam int Z_BIT = 2;
  localparam int V_BIT = 1;
  localparam int C_BIT = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_ADDA = 4'd3,
    OP_SWAP = 4'd4,
    OP_MULU = 4'd5,
    OP_LSL  = 4'd6,
    OP_LSR  = 4'd7,
    OP_ASR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_DIVU = 4'd11
  } aluOp_e;

  typedef struct packed {
    logic loadOp;
    logic divInit;
    logic divStep;
    logic divLast;
  } aluStrobe_t;
endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int STEPS = HALF_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       isDiv,
  input  logic       divBad,
  output aluStrobe_t strobe,
  output logic       busy
);
  localparam int STEP_CW = $clog2(STEPS);
  localparam logic [STEP_CW-1:0] LAST_STEP = STEP_CW'(STEPS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;
  ctrlState_e state;
  logic [STEP_CW-1:0] stepCnt;

  always_comb begin
    strobe = '0;
    if (state == ST_IDLE) begin
      if (start) begin
        if (isDiv && !divBad) strobe.divInit = 1'b1;
        else                  strobe.loadOp  = 1'b1;
      end
    end else begin
      strobe.divStep = 1'b1;
      strobe.divLast = (stepCnt == LAST_STEP);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      if (strobe.divInit) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end else if (state == ST_RUN) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobe.divLast) state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_RUN);

  // accepted divide keeps the block busy on the following cycle
  assert_div_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.divInit |=> busy);
  // busy only drops after the final divide step
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe.divLast) |=> busy);
  // a start seen while busy launches nothing
  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !(strobe.loadOp || strobe.divInit));
endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobe_t        strobe,
  input  logic [3:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [CCR_W-1:0]  ccrIn,
  output logic              isDiv,
  output logic              divBad,
  output logic [DATA_W-1:0] resultVal,
  output logic [CCR_W-1:0]  ccrOut,
  output logic              done,
  output logic              divErr
);
  // size decode
  logic [DATA_W-1:0] sizeMask;
  logic [6:0]        widthBits;
  logic [5:0]        msbIdx;
  always_comb begin
    unique case (sizeSel)
      2'd0:    begin sizeMask = 32'h0000_00FF; widthBits = 7'd8;  msbIdx = 6'd7;  end
      2'd1:    begin sizeMask = 32'h0000_FFFF; widthBits = 7'd16; msbIdx = 6'd15; end
      default: begin sizeMask = 32'hFFFF_FFFF; widthBits = 7'd32; msbIdx = 6'd31; end
    endcase
  end

  logic [DATA_W-1:0] dz, sz, sx;
  logic [CNT_W-1:0]  cnt, rotAmt;
  logic [DATA_W:0]   sumW, diffW;
  logic [63:0]       lslW, lsrW;
  logic [64:0]       asrW;
  logic [DATA_W-1:0] rolV, rorV, extSrc, prod;
  logic [6:0]        rotBack;

  assign dz      = dstVal & sizeMask;
  assign sz      = srcVal & sizeMask;
  assign sx      = dz[msbIdx] ? (dz | ~sizeMask) : dz;
  assign cnt     = srcVal[CNT_W-1:0];
  assign rotAmt  = cnt & CNT_W'(widthBits - 7'd1);
  assign rotBack = widthBits - {1'b0, rotAmt};
  assign sumW    = {1'b0, dz} + {1'b0, sz};
  assign diffW   = {1'b0, dz} - {1'b0, sz};
  assign lslW    = {32'b0, dz} << cnt;
  assign lsrW    = {31'b0, dz, 1'b0} >> cnt;
  assign asrW    = 65'($signed({{32{sx[31]}}, sx, 1'b0}) >>> cnt);
  assign rolV    = ((dz << rotAmt) | (dz >> rotBack)) & sizeMask;
  assign rorV    = ((dz >> rotAmt) | (dz << rotBack)) & sizeMask;
  assign extSrc  = sizeSel[1] ? srcVal : {{HALF_W{srcVal[HALF_W-1]}}, srcVal[HALF_W-1:0]};
  assign prod    = dstVal[HALF_W-1:0] * srcVal[HALF_W-1:0];

  assign isDiv  = (opSel == OP_DIVU);
  assign divBad = (srcVal[HALF_W-1:0] == '0) ||
                  (dstVal[DATA_W-1:HALF_W] >= srcVal[HALF_W-1:0]);

  // single-step result
  logic [DATA_W-1:0] sizedRes, fullRes, nextResult;
  logic [CCR_W-1:0]  nextCcr;
  logic              carryBit, ovfBit, sizedN, sizedZ, fullN, fullZ, dMsb, sMsb;

  always_comb begin
    sizedRes = dz;
    carryBit = 1'b0;
    unique case (opSel)
      OP_ADD:         begin sizedRes = sumW[DATA_W-1:0] & sizeMask;  carryBit = sumW[widthBits];  end
      OP_SUB, OP_CMP: begin sizedRes = diffW[DATA_W-1:0] & sizeMask; carryBit = diffW[widthBits]; end
      OP_LSL:         begin sizedRes = lslW[DATA_W-1:0] & sizeMask;  carryBit = lslW[widthBits];  end
      OP_LSR:         begin sizedRes = lsrW[DATA_W:1] & sizeMask;    carryBit = lsrW[0];          end
      OP_ASR:         begin sizedRes = asrW[DATA_W:1] & sizeMask;    carryBit = asrW[0];          end
      OP_ROL:         begin sizedRes = rolV;                         carryBit = rolV[0];          end
      OP_ROR:         begin sizedRes = rorV;                         carryBit = rorV[msbIdx];     end
      default:        begin sizedRes = dz;                           carryBit = 1'b0;             end
    endcase
  end

  assign dMsb   = dz[msbIdx];
  assign sMsb   = sz[msbIdx];
  assign sizedN = sizedRes[msbIdx];
  assign sizedZ = (sizedRes == '0);
  assign ovfBit = (opSel == OP_ADD) ? ((dMsb == sMsb) && (sizedN != dMsb))
                                    : ((dMsb != sMsb) && (sizedN != dMsb));

  always_comb begin
    unique case (opSel)
      OP_SWAP: fullRes = {dstVal[HALF_W-1:0], dstVal[DATA_W-1:HALF_W]};
      OP_MULU: fullRes = prod;
      default: fullRes = dstVal + extSrc;
    endcase
  end
  assign fullN = fullRes[DATA_W-1];
  assign fullZ = (fullRes == '0);

  always_comb begin
    nextResult = dstVal;
    nextCcr    = ccrIn;
    unique case (opSel)
      OP_ADD, OP_SUB: begin
        nextResult = (dstVal & ~sizeMask) | sizedRes;
        nextCcr    = {carryBit, sizedN, sizedZ, ovfBit, carryBit};
      end
      OP_CMP:  nextCcr = {ccrIn[X_BIT], sizedN, sizedZ, ovfBit, carryBit};
      OP_ADDA: nextResult = fullRes;
      OP_SWAP, OP_MULU: begin
        nextResult = fullRes;
        nextCcr    = {ccrIn[X_BIT], fullN, fullZ, 2'b00};
      end
      OP_LSL, OP_LSR, OP_ASR: begin
        nextResult = (dstVal & ~sizeMask) | sizedRes;
        if (cnt == '0) nextCcr = {ccrIn[X_BIT], sizedN, sizedZ, 2'b00};
        else           nextCcr = {carryBit, sizedN, sizedZ, 1'b0, carryBit};
      end
      OP_ROL, OP_ROR: begin
        nextResult = (dstVal & ~sizeMask) | sizedRes;
        nextCcr    = {ccrIn[X_BIT], sizedN, sizedZ, 1'b0, (cnt != '0) && carryBit};
      end
      OP_DIVU: begin
        nextCcr[V_BIT] = (srcVal[HALF_W-1:0] != '0);
        nextCcr[C_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  // restoring divider
  logic [HALF_W-1:0] divRem, divQuo, divisor, stepRem, stepQuo;
  logic [HALF_W:0]   trial;
  logic              savedX, takeBit;
  assign trial   = {divRem, divQuo[HALF_W-1]};
  assign takeBit = (trial >= {1'b0, divisor});
  assign stepRem = takeBit ? HALF_W'(trial - {1'b0, divisor}) : trial[HALF_W-1:0];
  assign stepQuo = {divQuo[HALF_W-2:0], takeBit};

  logic [DATA_W-1:0] resultReg;
  logic [CCR_W-1:0]  ccrReg;
  logic              doneReg, errReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultReg <= '0;
      ccrReg    <= '0;
      doneReg   <= 1'b0;
      errReg    <= 1'b0;
      divRem    <= '0;
      divQuo    <= '0;
      divisor   <= '0;
      savedX    <= 1'b0;
    end else begin
      doneReg <= strobe.loadOp || strobe.divLast;
      errReg  <= strobe.loadOp && isDiv && divBad;
      if (strobe.loadOp) begin
        resultReg <= nextResult;
        ccrReg    <= nextCcr;
      end
      if (strobe.divInit) begin
        divRem  <= dstVal[DATA_W-1:HALF_W];
        divQuo  <= dstVal[HALF_W-1:0];
        divisor <= srcVal[HALF_W-1:0];
        savedX  <= ccrIn[X_BIT];
      end
      if (strobe.divStep) begin
        divRem <= stepRem;
        divQuo <= stepQuo;
      end
      if (strobe.divLast) begin
        resultReg <= {stepRem, stepQuo};
        ccrReg    <= {savedX, stepQuo[HALF_W-1], stepQuo == '0, 2'b00};
      end
    end
  end

  assign resultVal = resultReg;
  assign ccrOut    = ccrReg;
  assign done      = doneReg;
  assign divErr    = errReg;

  // byte add/sub leaves upper destination bits alone
  assert_byte_merge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadOp && sizeSel == 2'd0 && (opSel == OP_ADD || opSel == OP_SUB))
      |=> resultVal[DATA_W-1:8] == $past(dstVal[DATA_W-1:8]));
  // compare never writes the destination and keeps X
  assert_cmp_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadOp && opSel == OP_CMP)
      |=> (resultVal == $past(dstVal)) && (ccrOut[X_BIT] == $past(ccrIn[X_BIT])));
  // address add leaves the flags as they were
  assert_adda_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadOp && opSel == OP_ADDA) |=> ccrOut == $past(ccrIn));
  // multiply and swap clear V and C
  assert_mul_vc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadOp && (opSel == OP_MULU || opSel == OP_SWAP))
      |=> (!ccrOut[V_BIT] && !ccrOut[C_BIT]));
  // rejected divide reports only together with done
  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    divErr |-> done);
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] dstVal,
  input  logic [CCR_W-1:0]  ccrIn,
  output logic [DATA_W-1:0] resultVal,
  output logic [CCR_W-1:0]  ccrOut,
  output logic              done,
  output logic              busy,
  output logic              divErr
);
  aluStrobe_t strobe;
  logic       isDiv, divBad;

  flag_alu_ctrl #(.STEPS(HALF_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .isDiv  (isDiv),
    .divBad (divBad),
    .strobe (strobe),
    .busy   (busy)
  );

  flag_alu_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .opSel     (opSel),
    .sizeSel   (sizeSel),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .ccrIn     (ccrIn),
    .isDiv     (isDiv),
    .divBad    (divBad),
    .resultVal (resultVal),
    .ccrOut    (ccrOut),
    .done      (done),
    .divErr    (divErr)
  );
endmodule

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = '0;
  logic [1:0]  sizeSel = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] dstVal = '0;
  logic [4:0]  ccrIn = '0;
  logic [31:0] resultVal;
  logic [4:0]  ccrOut;
  logic        done, busy, divErr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel), .sizeSel(sizeSel),
    .srcVal(srcVal), .dstVal(dstVal), .ccrIn(ccrIn), .resultVal(resultVal),
    .ccrOut(ccrOut), .done(done), .busy(busy), .divErr(divErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic [1:0] sz, input logic [31:0] s,
                       input logic [31:0] d, input logic [4:0] c, output int lat);
    @(negedge clk);
    opSel = op; sizeSel = sz; srcVal = s; dstVal = d; ccrIn = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic expectOp(input string req, input logic [3:0] op, input logic [1:0] sz,
                          input logic [31:0] s, input logic [31:0] d, input logic [4:0] c,
                          input logic [31:0] expRes, input logic [4:0] expCcr);
    int lat;
    runOp(op, sz, s, d, c, lat);
    check({req, " result"}, resultVal, expRes);
    check({req, " ccr"}, {27'b0, ccrOut}, {27'b0, expCcr});
    check({req, " latency R12"}, lat, (op == 4'd11 && !divErr && s[15:0] != 0 && d[31:16] < s[15:0]) ? 17 : 1);
  endtask

  task automatic testReset();
    check("R13 result", resultVal, 0);
    check("R13 ccr", {27'b0, ccrOut}, 0);
    check("R13 flags", {29'b0, done, busy, divErr}, 0);
  endtask

  task automatic testAdd();
    expectOp("R2 R1 add byte", 4'd0, 2'd0, 32'h12345678, 32'h22334455, 5'b00000, 32'h223344CD, 5'b01010);
    expectOp("R2 R1 add word", 4'd0, 2'd1, 32'h12345678, 32'h22334455, 5'b00000, 32'h22339ACD, 5'b01010);
    expectOp("R2 add long", 4'd0, 2'd2, 32'h12345678, 32'h22334455, 5'b11111, 32'h34679ACD, 5'b00000);
    expectOp("R2 add byte carry sized Z", 4'd0, 2'd0, 32'h00000001, 32'hAB0000FF, 5'b00000, 32'hAB000000, 5'b10101);
  endtask

  task automatic testSub();
    expectOp("R3 sub word borrow", 4'd1, 2'd1, 32'h00000005, 32'h00000003, 5'b00000, 32'h0000FFFE, 5'b11001);
    expectOp("R3 sub byte overflow", 4'd1, 2'd0, 32'h00000001, 32'h12345680, 5'b11111, 32'h1234567F, 5'b00010);
  endtask

  task automatic testCmp();
    expectOp("R4 cmp keeps X", 4'd2, 2'd1, 32'h00000003, 32'hABCD0005, 5'b10000, 32'hABCD0005, 5'b10000);
    expectOp("R4 cmp equal", 4'd2, 2'd1, 32'h00000003, 32'h00000003, 5'b00000, 32'h00000003, 5'b00100);
    expectOp("R4 cmp borrow X kept", 4'd2, 2'd1, 32'h00000002, 32'h00000001, 5'b00000, 32'h00000001, 5'b01001);
  endtask

  task automatic testAdda();
    expectOp("R5 adda word", 4'd3, 2'd1, 32'h2C34C11C, 32'h0112B33C, 5'b10110, 32'h01127458, 5'b10110);
    expectOp("R5 adda long", 4'd3, 2'd2, 32'h2C34C11C, 32'h0112B33C, 5'b01001, 32'h2D477458, 5'b01001);
  endtask

  task automatic testSwapMul();
    expectOp("R6 swap", 4'd4, 2'd2, 32'h0, 32'h12345678, 5'b10011, 32'h56781234, 5'b10000);
    expectOp("R7 mulu small", 4'd5, 2'd1, 32'h1234A678, 32'hA0120002, 5'b11111, 32'h00014CF0, 5'b10000);
    expectOp("R7 mulu big", 4'd5, 2'd0, 32'h336B4105, 32'hB11CA024, 5'b00000, 32'h28AC44B4, 5'b00000);
  endtask

  task automatic testShift();
    expectOp("R8 lsl byte", 4'd6, 2'd0, 32'd2, 32'h000000C1, 5'b00000, 32'h00000004, 5'b10001);
    expectOp("R8 lsr word", 4'd7, 2'd1, 32'd1, 32'h00008003, 5'b00000, 32'h00004001, 5'b10001);
    expectOp("R8 asr byte", 4'd8, 2'd0, 32'd1, 32'h00000081, 5'b00000, 32'h000000C0, 5'b11001);
    expectOp("R8 asr byte long count", 4'd8, 2'd0, 32'd10, 32'h00000081, 5'b00000, 32'h000000FF, 5'b11001);
    expectOp("R8 lsl zero count", 4'd6, 2'd2, 32'd0, 32'h12345678, 5'b10001, 32'h12345678, 5'b10000);
    expectOp("R8 lsl long by 32", 4'd6, 2'd2, 32'd32, 32'h00000001, 5'b00000, 32'h00000000, 5'b10101);
  endtask

  task automatic testRotate();
    expectOp("R9 R1 rol byte", 4'd9, 2'd0, 32'd1, 32'hFFFFFF81, 5'b00000, 32'hFFFFFF03, 5'b00001);
    expectOp("R9 ror word", 4'd10, 2'd1, 32'd1, 32'h00000001, 5'b10000, 32'h00008000, 5'b11001);
    expectOp("R9 rol byte count 9", 4'd9, 2'd0, 32'd9, 32'h00000081, 5'b00000, 32'h00000003, 5'b00001);
    expectOp("R9 ror zero count", 4'd10, 2'd0, 32'd0, 32'h00000081, 5'b10000, 32'h00000081, 5'b11000);
  endtask

  task automatic testDivide();
    expectOp("R10 divu", 4'd11, 2'd2, 32'h1C32A024, 32'h28AC44B5, 5'b10000, 32'h00014105, 5'b10000);
    expectOp("R10 divu negative quotient", 4'd11, 2'd2, 32'h00000001, 32'h0000FFFF, 5'b00000, 32'h0000FFFF, 5'b01000);
    expectOp("R10 divu zero quotient", 4'd11, 2'd2, 32'h00000005, 32'h00000003, 5'b00000, 32'h00030000, 5'b00100);
  endtask

  task automatic testDivErr();
    int lat;
    runOp(4'd11, 2'd2, 32'hFFFF0000, 32'h12345678, 5'b01110, lat);
    check("R11 div zero err", {31'b0, divErr}, 1);
    check("R11 div zero result", resultVal, 32'h12345678);
    check("R11 div zero ccr", {27'b0, ccrOut}, {27'b0, 5'b01100});
    check("R11 div zero latency", lat, 1);
    runOp(4'd11, 2'd2, 32'h00000004, 32'h00050000, 5'b00000, lat);
    check("R11 div ovf err", {31'b0, divErr}, 1);
    check("R11 div ovf result", resultVal, 32'h00050000);
    check("R11 div ovf ccr", {27'b0, ccrOut}, {27'b0, 5'b00010});
    runOp(4'd0, 2'd2, 32'h1, 32'h1, 5'b00000, lat);
    check("R11 no err on add", {31'b0, divErr}, 0);
  endtask

  task automatic testBusyIgnore();
    int lat;
    int extraDone;
    extraDone = 0;
    @(negedge clk);
    opSel = 4'd11; sizeSel = 2'd2; srcVal = 32'h1C32A024; dstVal = 32'h28AC44B5; ccrIn = 5'b00000; start = 1'b1;
    @(negedge clk);
    check("R10 busy after start", {31'b0, busy}, 1);
    opSel = 4'd0; srcVal = 32'h11111111; dstVal = 32'h22222222; start = 1'b1;
    lat = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      lat++;
      if (done) extraDone++;
    end
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R12 no done from ignored start", extraDone, 0);
    check("R12 R10 latency with ignored start", lat, 17);
    check("R12 divide result survives", resultVal, 32'h00014105);
    @(negedge clk);
    check("R10 busy cleared", {30'b0, busy, done}, 0);
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testAdd();
    testSub();
    testCmp();
    testAdda();
    testSwapMul();
    testShift();
    testRotate();
    testDivide();
    testDivErr();
    testBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule